// File: doc/BRIEF.md
# Port Change Detector with Read Snapshot

This block watches a six-bit input port and raises a sticky change flag when any watched pin differs from the value the port held at the last time software accessed it. Each pin has its own watch-enable bit. The pins first pass through a two-stage synchronizer. The synchronized value is what software reads from the port. Every port access loads a snapshot register with that value.

The comparison is made against the snapshot, not against the previous clock. A difference therefore persists until software accesses the port again. While it persists, the flag is re-asserted on every cycle and a clear cannot take hold. The intended service order is: access the port, then clear the flag.

The flag also drives a wake request while the device is asleep. A warm reset clears the flag but keeps the snapshot and the enables, so an unresolved difference sets the flag again once the warm reset ends. When the two upper pins serve a crystal oscillator, their enables read back as zero and cannot raise the flag.

Top module: `ioc_mismatch`

## Requirements
- R1: While `por_n` is low, and for two clock edges after it rises, `chg_flag`, `wake_o`, `rd_data` and `en_rdata` are all 0 and the snapshot is 0. Assertion of `por_n` takes effect without waiting for a clock.
- R2: `rd_data` equals `pin_i` as sampled two rising edges earlier.
- R3: When a watched bit of `rd_data` differs from the snapshot and `warm_n` is high, `chg_flag` is 1 after the next rising edge.
- R4: A pin whose watch-enable bit is 0 never causes `chg_flag` to rise.
- R5: A cycle with `port_acc` high loads the snapshot with the current `rd_data`. Without `port_acc` the snapshot holds its value.
- R6: A `flag_clr` pulse lowers `chg_flag` at the next edge only if no watched mismatch exists in that cycle. Otherwise the flag stays 1.
- R7: When a mismatch and `flag_clr` occur in the same cycle, the flag is set. This includes a cycle that also carries `port_acc`, because the comparison in that cycle still uses the old snapshot.
- R8: While `warm_n` is low, `chg_flag` is 0 from the next edge on. The enables and the snapshot are kept, so a remaining mismatch sets the flag again one edge after `warm_n` returns high.
- R9: With `xtal_mode` high, bits 5 and 4 of `en_rdata` read 0 and pins 5 and 4 cannot set the flag.
- R10: `wake_o` is 1 exactly when `chg_flag` is 1 and `asleep` is 1.
- R11: Once set, `chg_flag` stays 1 after the mismatch ends, until a successful clear or a reset.
- R12: `en_wr` loads `en_wdata` into the watch-enable register at the next edge. `en_rdata` shows the stored bits, with bits 5:4 masked as given in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low. Asserted asynchronously, released synchronously. |
| warm_n | input | 1 | Warm reset, active low, synchronous. Clears only the flag. |
| pin_i | input | 6 | Raw port pins |
| port_acc | input | 1 | Port read or write strobe. Loads the snapshot. |
| rd_data | output | 6 | Synchronized port value |
| en_wr | input | 1 | Write strobe for the watch-enable register |
| en_wdata | input | 6 | Watch-enable write data |
| en_rdata | output | 6 | Watch-enable read-back |
| xtal_mode | input | 1 | Pins 5:4 serve the oscillator |
| flag_clr | input | 1 | Flag-clear strobe |
| asleep | input | 1 | Device is in sleep |
| chg_flag | output | 1 | Sticky change flag |
| wake_o | output | 1 | Wake request |

## Verification
A flag set and a flag clear can land on the same edge. The bench provokes this in two ways. First, it holds `flag_clr` high across the edge where a freshly synchronized pin change first mismatches. Second, it pulses `port_acc` and `flag_clr` together while a mismatch is standing, so the comparison in that cycle still sees the old snapshot. In both cases the flag must read 1 afterwards. A plain clear on the following cycle must then bring it to 0, and the per-cycle reference model judges every edge in between.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int unsigned IOC_PINS = 6;
  typedef logic [IOC_PINS-1:0] pin_vec_t;
  // pins that the oscillator takes over in crystal mode
  localparam pin_vec_t IOC_XTAL_HIDE = pin_vec_t'(6'b110000);
endpackage

// File: rtl/ioc_rst_sync.sv
module ioc_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[DEPTH-1];
endmodule

// File: rtl/ioc_sync.sv
module ioc_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ioc_cfg.sv
module ioc_cfg #(
  parameter int unsigned W    = 6,
  parameter logic [W-1:0] HIDE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         xtal_i,
  output logic [W-1:0] en_eff_o,
  output logic [W-1:0] en_rd_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] en_d;
  logic [W-1:0] mask;

  always_comb begin
    en_d = wr_i ? wdata_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= en_d;
  end

  always_comb begin
    mask     = xtal_i ? HIDE : '0;
    en_eff_o = en_q & ~mask;
    en_rd_o  = en_eff_o;
  end
endmodule

// File: rtl/ioc_detect.sv
module ioc_detect #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_i,
  input  logic [W-1:0] pin_s_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] snap_o,
  output logic         mismatch_o
);
  logic [W-1:0] snap_q;
  logic [W-1:0] snap_d;
  logic [W-1:0] diff;

  always_comb begin
    snap_d = acc_i ? pin_s_i : snap_q;
  end

  // snapshot sees only the power-on reset, never the warm reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_q <= '0;
    else if (acc_i) snap_q <= snap_d;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign diff[i] = (pin_s_i[i] ^ snap_q[i]) & en_i[i];
  end

  assign mismatch_o = |diff;
  assign snap_o     = snap_q;
endmodule

// File: rtl/ioc_flag.sv
module ioc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic warm_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    if (!warm_n)    flag_d = 1'b0;
    else if (set_i) flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ioc_mismatch.sv
module ioc_mismatch #(
  parameter int unsigned     PINS        = ioc_pkg::IOC_PINS,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [PINS-1:0] HIDE        = ioc_pkg::IOC_XTAL_HIDE
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            warm_n,
  input  logic [PINS-1:0] pin_i,
  input  logic            port_acc,
  output logic [PINS-1:0] rd_data,
  input  logic            en_wr,
  input  logic [PINS-1:0] en_wdata,
  output logic [PINS-1:0] en_rdata,
  input  logic            xtal_mode,
  input  logic            flag_clr,
  input  logic            asleep,
  output logic            chg_flag,
  output logic            wake_o
);
  logic            rst_n;
  logic [PINS-1:0] pin_s;
  logic [PINS-1:0] en_eff;
  logic [PINS-1:0] snap;
  logic            mismatch;

  ioc_rst_sync #(.DEPTH(2)) u_rst (
    .clk(clk), .arst_n(por_n), .rst_n_o(rst_n)
  );

  ioc_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  ioc_cfg #(.W(PINS), .HIDE(HIDE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(en_wr), .wdata_i(en_wdata),
    .xtal_i(xtal_mode), .en_eff_o(en_eff), .en_rd_o(en_rdata)
  );

  ioc_detect #(.W(PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .acc_i(port_acc), .pin_s_i(pin_s),
    .en_i(en_eff), .snap_o(snap), .mismatch_o(mismatch)
  );

  ioc_flag u_flag (
    .clk(clk), .rst_n(rst_n), .warm_n(warm_n), .set_i(mismatch),
    .clr_i(flag_clr), .flag_o(chg_flag)
  );

  assign rd_data = pin_s;
  assign wake_o  = chg_flag & asleep;
endmodule

// File: rtl/ioc_mismatch_chk.sv
module ioc_mismatch_chk #(
  parameter int unsigned  W    = 6,
  parameter logic [W-1:0] HIDE = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         warm_n,
  input logic         port_acc,
  input logic         flag_clr,
  input logic         xtal_mode,
  input logic [W-1:0] pin_s,
  input logic [W-1:0] snap,
  input logic         mismatch,
  input logic         chg_flag,
  input logic         wake_o,
  input logic [W-1:0] en_rdata
);
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_n && mismatch) |=> chg_flag);

  p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_flag) |-> $past(mismatch));

  p_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    port_acc |=> (snap == $past(pin_s)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !port_acc |=> $stable(snap));

  p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_n && flag_clr && !mismatch) |=> !chg_flag);

  p_warm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_n |=> !chg_flag);

  p_xtal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xtal_mode |-> ((en_rdata & HIDE) == '0));

  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> chg_flag);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_n && chg_flag && !flag_clr) |=> chg_flag);
endmodule

bind ioc_mismatch ioc_mismatch_chk #(.W(PINS), .HIDE(HIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .warm_n(warm_n), .port_acc(port_acc),
  .flag_clr(flag_clr), .xtal_mode(xtal_mode), .pin_s(pin_s), .snap(snap),
  .mismatch(mismatch), .chg_flag(chg_flag), .wake_o(wake_o),
  .en_rdata(en_rdata)
);

// File: tb/sim_ioc_mismatch.sv
`timescale 1ns/1ps
module sim_ioc_mismatch;
  localparam logic [5:0] HIDE = 6'b110000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       por_n, warm_n, port_acc, en_wr, xtal_mode, flag_clr, asleep;
  logic [5:0] pin_i, en_wdata, rd_data, en_rdata;
  logic       chg_flag, wake_o;

  ioc_mismatch u0 (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .pin_i(pin_i),
    .port_acc(port_acc), .rd_data(rd_data), .en_wr(en_wr),
    .en_wdata(en_wdata), .en_rdata(en_rdata), .xtal_mode(xtal_mode),
    .flag_clr(flag_clr), .asleep(asleep), .chg_flag(chg_flag),
    .wake_o(wake_o)
  );

  int n_run  = 0;
  int n_fail = 0;
  string cur = "R1";

  // behavioural reference: queue of pending samples, plain variables
  logic [5:0] q[$] = '{6'h00, 6'h00};
  logic [5:0] m_en   = 6'h00;
  logic [5:0] m_snap = 6'h00;
  logic       m_flag = 1'b0;
  int         live   = 0;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      live = 0; m_en = 0; m_snap = 0; m_flag = 0; q = '{6'h00, 6'h00};
    end else if (live < 2) begin
      live++;
    end else begin
      logic [5:0] eff;
      logic       mism;
      eff  = m_en & ~(xtal_mode ? HIDE : 6'h00);
      mism = |((q[0] ^ m_snap) & eff);
      if (!warm_n)       m_flag = 1'b0;
      else if (mism)     m_flag = 1'b1;
      else if (flag_clr) m_flag = 1'b0;
      if (port_acc) m_snap = q[0];
      if (en_wr)    m_en   = en_wdata;
      q.push_back(pin_i);
      void'(q.pop_front());
    end
  end

  task automatic chk(string req, string what, logic [5:0] act, logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(cur, "rd_data", rd_data, q[0]);
    chk(cur, "en_rdata", en_rdata, m_en & ~(xtal_mode ? HIDE : 6'h00));
    chk(cur, "chg_flag", {5'b0, chg_flag}, {5'b0, m_flag});
    chk(cur, "wake_o", {5'b0, wake_o}, {5'b0, m_flag & asleep});
  endtask

  task automatic flag_is(logic e);
    chk(cur, "flag direct", {5'b0, chg_flag}, {5'b0, e});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    por_n = 0; warm_n = 1; pin_i = 0; port_acc = 0; en_wr = 0;
    en_wdata = 0; xtal_mode = 0; flag_clr = 0; asleep = 0;
    // R1 reset state
    cur = "R1"; repeat (3) tick();
    por_n = 1; repeat (3) tick();
    flag_is(0); chk("R1", "en direct", en_rdata, 6'h00);

    // R2 and R4: pins move, nothing watched
    cur = "R4"; pin_i = 6'h2A; repeat (4) tick();
    flag_is(0); chk("R2", "rd direct", rd_data, 6'h2A);

    // R12 and R3: enable all, standing difference sets the flag
    cur = "R3"; en_wr = 1; en_wdata = 6'h3F; tick(); en_wr = 0;
    chk("R12", "en direct", en_rdata, 6'h3F);
    tick(); flag_is(1);

    // R11: access ends mismatch, flag stays
    cur = "R11"; port_acc = 1; tick(); port_acc = 0; repeat (3) tick();
    flag_is(1);

    // R6: clear works once the difference is gone
    cur = "R6"; flag_clr = 1; tick(); flag_clr = 0; tick(); flag_is(0);
    pin_i = 6'h2B; repeat (3) tick(); flag_is(1);
    flag_clr = 1; repeat (2) tick(); flag_clr = 0; tick(); flag_is(1);
    port_acc = 1; tick(); port_acc = 0;
    flag_clr = 1; tick(); flag_clr = 0; tick(); flag_is(0);

    // R7: set and clear on the same edge
    cur = "R7"; pin_i = 6'h0B; repeat (2) tick();
    flag_clr = 1; repeat (2) tick(); flag_clr = 0; flag_is(1);
    port_acc = 1; flag_clr = 1; tick(); port_acc = 0; flag_clr = 0;
    flag_is(1);
    flag_clr = 1; tick(); flag_clr = 0; flag_is(0);

    // R8: warm reset clears flag, keeps snapshot and enables
    cur = "R8"; pin_i = 6'h0A; repeat (4) tick(); flag_is(1);
    warm_n = 0; repeat (2) tick(); flag_is(0);
    chk("R8", "en kept", en_rdata, 6'h3F);
    warm_n = 1; tick(); flag_is(1);
    port_acc = 1; tick(); port_acc = 0;
    flag_clr = 1; tick(); flag_clr = 0; tick(); flag_is(0);

    // R9: oscillator pins hidden
    cur = "R9"; xtal_mode = 1; tick();
    chk("R9", "en masked", en_rdata, 6'h0F);
    pin_i = 6'h3A; repeat (4) tick(); flag_is(0);
    pin_i = 6'h38; repeat (3) tick(); flag_is(1);

    // R10: wake follows flag while asleep
    cur = "R10"; asleep = 1; tick();
    chk("R10", "wake direct", {5'b0, wake_o}, 6'h01);
    asleep = 0; tick();
    chk("R10", "wake direct", {5'b0, wake_o}, 6'h00);

    // R5: access loads snapshot, then clear succeeds
    cur = "R5"; port_acc = 1; tick(); port_acc = 0;
    flag_clr = 1; tick(); flag_clr = 0; tick(); flag_is(0);
    chk("R5", "rd direct", rd_data, 6'h38);
    xtal_mode = 0; repeat (3) tick(); flag_is(0);

    // R1: asynchronous power-on reset mid-run
    cur = "R1"; pin_i = 6'h39; repeat (3) tick(); flag_is(1);
    #1 por_n = 0; tick(); flag_is(0);
    chk("R1", "en reset", en_rdata, 6'h00);
    chk("R1", "rd reset", rd_data, 6'h00);
    @(negedge clk); por_n = 1; repeat (4) tick();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule